// File: doc/BRIEF.md
# Interrupt and Reset Event Router

This block collects events from the monitors around a supply and bus controller and turns each one into either a latched interrupt flag or a reset request. The monitors cover temperature, ground shift, SPI frame length, a sense input, supply short circuits, CAN and LIN bus failures, the wake pin and the watchdog. Each source has an enable bit. For the watchdog, the SPI length check and the wake pin, the enable bit and the current operating mode together decide whether the event becomes an interrupt, a reset, or nothing.

The asynchronous monitor levels pass through two-stage synchronizers before edge or change detection. The watchdog overflow and the SPI length error come from logic on the same clock and are taken as one-cycle pulses. Flags stay set until software clears them through a per-bit clear strobe. An active-low interrupt line is asserted while any flag is set.

Top module: `evr_event_router`

## Requirements
- R1: After reset, all flags are 0, irq_no is 1 and rst_req_o is 0. Flag and enable bit positions are: 0 watchdog, 1 temperature, 2 ground shift, 3 SPI length, 4 sense, 5 supply short, 6 CAN failure, 7 LIN failure, 8 wake.
- R2: With its enable set, a change of the temperature level in either direction sets flag bit 1, and a change of the ground-shift level sets bit 2. An asynchronous input change first sampled at clock edge N shows on flags_o after edge N+2. With the enable clear, the flag stays clear.
- R3: With its enable set, any change of the CAN failure level sets bit 6, and any change of the LIN failure level sets bit 7.
- R4: With its enable set, a falling edge of sense_i sets bit 4. A rising edge does nothing.
- R5: With its enable set, a rising edge of the OR of short_v2_i and short_v3_i sets bit 5.
- R6: A watchdog overflow pulse in Standby mode (code 3) with enable bit 0 set sets flag bit 0 after the same edge. In every other case the pulse requests a reset.
- R7: An SPI length error pulse with enable bit 3 set requests a reset in Start-up (code 0) or Restart (code 1) mode, and sets flag bit 3 in any other mode. With the enable clear, the pulse is ignored.
- R8: A falling edge of wake_i with enable bit 8 set sets flag bit 8 in Normal (2), Standby (3) or Flash (4) mode. With the enable clear, it requests a reset in Standby mode. Every other case is ignored.
- R9: A flag stays set until a cycle in which its clr_i bit is 1 clears it. A set event in that same cycle keeps the flag set.
- R10: irq_no is 0 exactly while at least one flag is set.
- R11: rst_req_o is a registered pulse that is never high for two cycles in a row. A reset cause arriving while the pulse is high is merged into that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| en_i | input | 9 | Per-source enable bits |
| wdog_ovf_i | input | 1 | Watchdog overflow pulse (synchronous) |
| spi_len_err_i | input | 1 | SPI frame length error pulse (synchronous) |
| temp_warn_i | input | 1 | Temperature warning level (asynchronous) |
| gnd_shift_i | input | 1 | Ground shift warning level (asynchronous) |
| sense_i | input | 1 | Sense input level (asynchronous) |
| short_v2_i | input | 1 | Supply 2 short indication (asynchronous) |
| short_v3_i | input | 1 | Supply 3 short indication (asynchronous) |
| can_fail_i | input | 1 | CAN failure status level (asynchronous) |
| lin_fail_i | input | 1 | LIN failure status level (asynchronous) |
| wake_i | input | 1 | Wake pin level (asynchronous) |
| clr_i | input | 9 | Per-flag clear strobe |
| flags_o | output | 9 | Latched interrupt flags |
| irq_no | output | 1 | Interrupt line, active low |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Directed steps drive single crossings of each level in both directions. These show whether a source detects any change, only falling edges or only rising edges, and whether the latency from sampling to flag is right. The watchdog, SPI and wake events are repeated across every mode code with the enable set and then clear, which tells apart the interrupt, reset and ignore routes. A long random phase then mixes toggles, pulses, mode changes and clears that coincide with new events, and compares every cycle against a behavioural model. This exposes errors in set-versus-clear priority and in merging back-to-back reset pulses.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int NSRC   = 9;
  localparam int NASYNC = 8;
  localparam int NDET   = 7;

  typedef enum logic [2:0] {
    MODE_STARTUP = 3'd0,
    MODE_RESTART = 3'd1,
    MODE_NORMAL  = 3'd2,
    MODE_STANDBY = 3'd3,
    MODE_FLASH   = 3'd4,
    MODE_SLEEP   = 3'd5
  } mode_e;

  // flag / enable positions
  localparam int SRC_WDOG  = 0;
  localparam int SRC_TEMP  = 1;
  localparam int SRC_GND   = 2;
  localparam int SRC_SPI   = 3;
  localparam int SRC_SENSE = 4;
  localparam int SRC_SHORT = 5;
  localparam int SRC_CAN   = 6;
  localparam int SRC_LIN   = 7;
  localparam int SRC_WAKE  = 8;

  // detector slots
  localparam int DET_TEMP  = 0;
  localparam int DET_GND   = 1;
  localparam int DET_SENSE = 2;
  localparam int DET_SHORT = 3;
  localparam int DET_CAN   = 4;
  localparam int DET_LIN   = 5;
  localparam int DET_WAKE  = 6;

  typedef enum logic [1:0] {
    KIND_ANY  = 2'd0,
    KIND_FALL = 2'd1,
    KIND_RISE = 2'd2
  } det_kind_e;

  function automatic det_kind_e kind_of(int slot);
    case (slot)
      DET_SENSE, DET_WAKE: return KIND_FALL;
      DET_SHORT:           return KIND_RISE;
      default:             return KIND_ANY;
    endcase
  endfunction
endpackage

// File: rtl/evr_sync.sv
module evr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/evr_detect.sv
module evr_detect
  import evr_pkg::*;
#(
  parameter det_kind_e KIND = KIND_ANY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  if (KIND == KIND_FALL) begin : g_fall
    assign evt_o = prev_q & ~lvl_i;
  end else if (KIND == KIND_RISE) begin : g_rise
    assign evt_o = ~prev_q & lvl_i;
  end else begin : g_any
    assign evt_o = prev_q ^ lvl_i;
  end
endmodule

// File: rtl/evr_route.sv
module evr_route
  import evr_pkg::*;
(
  input  logic [2:0]      mode_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            wdog_i,
  input  logic            spi_i,
  input  logic [NDET-1:0] evt_i,
  output logic [NSRC-1:0] set_o,
  output logic            rst_cause_o
);
  logic standby, boot, awake;

  always_comb begin
    standby = (mode_i == MODE_STANDBY);
    boot    = (mode_i == MODE_STARTUP) || (mode_i == MODE_RESTART);
    awake   = (mode_i == MODE_NORMAL) || (mode_i == MODE_FLASH) || standby;

    set_o            = '0;
    set_o[SRC_WDOG]  = wdog_i & en_i[SRC_WDOG] & standby;
    set_o[SRC_TEMP]  = evt_i[DET_TEMP] & en_i[SRC_TEMP];
    set_o[SRC_GND]   = evt_i[DET_GND] & en_i[SRC_GND];
    set_o[SRC_SPI]   = spi_i & en_i[SRC_SPI] & ~boot;
    set_o[SRC_SENSE] = evt_i[DET_SENSE] & en_i[SRC_SENSE];
    set_o[SRC_SHORT] = evt_i[DET_SHORT] & en_i[SRC_SHORT];
    set_o[SRC_CAN]   = evt_i[DET_CAN] & en_i[SRC_CAN];
    set_o[SRC_LIN]   = evt_i[DET_LIN] & en_i[SRC_LIN];
    set_o[SRC_WAKE]  = evt_i[DET_WAKE] & en_i[SRC_WAKE] & awake;

    rst_cause_o = (wdog_i & ~(en_i[SRC_WDOG] & standby))
                | (spi_i & en_i[SRC_SPI] & boot)
                | (evt_i[DET_WAKE] & ~en_i[SRC_WAKE] & standby);
  end
endmodule

// File: rtl/evr_event_router.sv
module evr_event_router
  import evr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      mode_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            wdog_ovf_i,
  input  logic            spi_len_err_i,
  input  logic            temp_warn_i,
  input  logic            gnd_shift_i,
  input  logic            sense_i,
  input  logic            short_v2_i,
  input  logic            short_v3_i,
  input  logic            can_fail_i,
  input  logic            lin_fail_i,
  input  logic            wake_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flags_o,
  output logic            irq_no,
  output logic            rst_req_o
);
  logic [NASYNC-1:0] raw, synced;
  logic [NDET-1:0]   lvl, evt;
  logic [NSRC-1:0]   set, flag_q;
  logic              rst_cause, rst_q;

  assign raw = {wake_i, lin_fail_i, can_fail_i, short_v3_i, short_v2_i,
                sense_i, gnd_shift_i, temp_warn_i};

  evr_sync #(.W(NASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  always_comb begin
    lvl            = '0;
    lvl[DET_TEMP]  = synced[0];
    lvl[DET_GND]   = synced[1];
    lvl[DET_SENSE] = synced[2];
    lvl[DET_SHORT] = synced[3] | synced[4];
    lvl[DET_CAN]   = synced[5];
    lvl[DET_LIN]   = synced[6];
    lvl[DET_WAKE]  = synced[7];
  end

  for (genvar d = 0; d < NDET; d++) begin : g_det
    evr_detect #(.KIND(kind_of(d))) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl[d]),
      .evt_o (evt[d])
    );
  end

  evr_route u_route (
    .mode_i     (mode_i),
    .en_i       (en_i),
    .wdog_i     (wdog_ovf_i),
    .spi_i      (spi_len_err_i),
    .evt_i      (evt),
    .set_o      (set),
    .rst_cause_o(rst_cause)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set;
  end

  // merge back-to-back causes into one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= rst_cause & ~rst_q;
  end

  assign flags_o   = flag_q;
  assign irq_no    = ~|flag_q;
  assign rst_req_o = rst_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
    p_set_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flags_o[i] && !en_i[i]) |=> !flags_o[i]);
  end

  p_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  p_wdog_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_ovf_i && en_i[SRC_WDOG] && mode_i == MODE_STANDBY) |=> flags_o[SRC_WDOG]);

  p_wdog_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_ovf_i && mode_i != MODE_STANDBY && !rst_req_o) |=> rst_req_o);

  p_spi_boot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_len_err_i && en_i[SRC_SPI] && (mode_i == MODE_STARTUP || mode_i == MODE_RESTART)
     && !rst_req_o) |=> rst_req_o);

  p_irq_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[SRC_TEMP]) |-> !irq_no);
endmodule

// File: tb/evr_event_router_test.sv
`timescale 1ns/1ps
module evr_event_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd2;
  logic [8:0] en = '0, clr = '0;
  logic wdog = 0, spi = 0, temp = 0, gnd = 0, sense = 1, v2 = 0, v3 = 0;
  logic can = 0, lin = 0, wake = 1;
  logic [8:0] flags;
  logic irq_n, rst_req;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evr_event_router uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_i(en),
    .wdog_ovf_i(wdog), .spi_len_err_i(spi), .temp_warn_i(temp),
    .gnd_shift_i(gnd), .sense_i(sense), .short_v2_i(v2), .short_v3_i(v3),
    .can_fail_i(can), .lin_fail_i(lin), .wake_i(wake), .clr_i(clr),
    .flags_o(flags), .irq_no(irq_n), .rst_req_o(rst_req)
  );

  // behavioural reference
  logic [8:0] m_flags;
  logic       m_rst;
  logic [8:0] m_clr_last;
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0; m_rst = 0; m_clr_last = '0;
      hist = {8'h00, 8'h00, 8'h00};
    end else begin
      logic [7:0] o, n;
      logic [8:0] s;
      bit cause;
      o = hist[0]; n = hist[1];
      s = '0; cause = 0;
      if (wdog) begin
        if (en[0] && mode == 3) s[0] = 1; else cause = 1;
      end
      if (en[1] && (o[0] != n[0])) s[1] = 1;
      if (en[2] && (o[1] != n[1])) s[2] = 1;
      if (spi && en[3]) begin
        if (mode == 0 || mode == 1) cause = 1; else s[3] = 1;
      end
      if (en[4] && o[2] && !n[2]) s[4] = 1;
      if (en[5] && !(o[3] || o[4]) && (n[3] || n[4])) s[5] = 1;
      if (en[6] && (o[5] != n[5])) s[6] = 1;
      if (en[7] && (o[6] != n[6])) s[7] = 1;
      if (o[7] && !n[7]) begin
        if (en[8] && (mode == 2 || mode == 3 || mode == 4)) s[8] = 1;
        else if (!en[8] && mode == 3) cause = 1;
      end
      m_clr_last = clr;
      m_flags = (m_flags & ~clr) | s;
      m_rst = cause && !m_rst;
      hist.push_back({wake, lin, can, v3, v2, sense, gnd, temp});
      void'(hist.pop_front());
    end
  end

  function automatic string req_of(int b);
    case (b)
      0: return "R6"; 1, 2: return "R2"; 3: return "R7"; 4: return "R4";
      5: return "R5"; 6, 7: return "R3"; default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare against model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int b = 0; b < 9; b++)
        if (flags[b] !== m_flags[b])
          check(0, (m_clr_last[b] ? "R9" : req_of(b)), flags, m_flags);
      check(irq_n === (m_flags == 0), "R10", irq_n, m_flags == 0);
      check(rst_req === m_rst, "R11", rst_req, m_rst);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wdog(logic [2:0] md, bit e, bit exp_flag, bit exp_rst);
    mode = md; en[0] = e; clr = 9'h1FF; cyc(1); clr = '0; cyc(2);
    wdog = 1; cyc(1); wdog = 0;
    check(flags[0] == exp_flag, "R6", flags[0], exp_flag);
    check(rst_req == exp_rst, "R6", rst_req, exp_rst);
  endtask

  task automatic pulse_spi(logic [2:0] md, bit e, bit exp_flag, bit exp_rst);
    mode = md; en[3] = e; clr = 9'h1FF; cyc(1); clr = '0; cyc(2);
    spi = 1; cyc(1); spi = 0;
    check(flags[3] == exp_flag, "R7", flags[3], exp_flag);
    check(rst_req == exp_rst, "R7", rst_req, exp_rst);
  endtask

  task automatic fall_wake(logic [2:0] md, bit e, bit exp_flag, bit exp_rst);
    mode = md; en[8] = e; clr = 9'h1FF; cyc(1); clr = '0; cyc(2);
    wake = 0; cyc(3);
    check(flags[8] == exp_flag, "R8", flags[8], exp_flag);
    check(rst_req == exp_rst, "R8", rst_req, exp_rst);
    wake = 1; cyc(4);
  endtask

  initial begin : wdog_timer
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(4);
    check(flags == 0 && irq_n == 1 && rst_req == 0, "R1", {flags, irq_n, rst_req}, 2);
    rst_n = 1; cyc(4);
    check(flags == 0 && irq_n == 1, "R1", flags, 0);

    // R2 latency and both directions
    en = 9'h1FF; mode = 3'd2;
    temp = 1; cyc(2);
    check(flags[1] == 0, "R2", flags[1], 0);
    cyc(1);
    check(flags[1] == 1, "R2", flags[1], 1);
    check(irq_n == 0, "R10", irq_n, 0);
    clr = 9'h002; cyc(1); clr = '0;
    check(flags[1] == 0, "R9", flags[1], 0);
    check(irq_n == 1, "R10", irq_n, 1);
    temp = 0; cyc(3);
    check(flags[1] == 1, "R2", flags[1], 1);
    en[2] = 0; gnd = 1; cyc(4);
    check(flags[2] == 0, "R2", flags[2], 0);
    en[2] = 1;

    // R3 change detection
    can = 1; lin = 1; cyc(3);
    check(flags[7:6] == 2'b11, "R3", flags[7:6], 3);
    clr = 9'h0C0; cyc(1); clr = '0;
    can = 0; cyc(3);
    check(flags[7:6] == 2'b01, "R3", flags[7:6], 1);

    // R4 sense edges
    clr = 9'h1FF; cyc(1); clr = '0;
    sense = 0; cyc(3);
    check(flags[4] == 1, "R4", flags[4], 1);
    clr = 9'h010; cyc(1); clr = '0;
    sense = 1; cyc(3);
    check(flags[4] == 0, "R4", flags[4], 0);

    // R5 short on either supply
    v3 = 1; cyc(3);
    check(flags[5] == 1, "R5", flags[5], 1);
    clr = 9'h020; cyc(1); clr = '0;
    v2 = 1; cyc(3);
    check(flags[5] == 0, "R5", flags[5], 0);
    v2 = 0; v3 = 0; cyc(4);

    // R9 set wins over clear
    clr = 9'h1FF; cyc(1); clr = '0;
    temp = 1; cyc(2); clr = 9'h002; cyc(1); clr = '0;
    check(flags[1] == 1, "R9", flags[1], 1);

    // R6 / R7 / R8 routing across modes
    for (int m = 0; m < 6; m++) begin
      pulse_wdog(3'(m), 1, m == 3, m != 3);
      pulse_wdog(3'(m), 0, 0, 1);
      pulse_spi(3'(m), 1, m > 1, m < 2);
      pulse_spi(3'(m), 0, 0, 0);
      fall_wake(3'(m), 1, m >= 2 && m <= 4, 0);
      fall_wake(3'(m), 0, 0, m == 3);
    end

    // R11 back-to-back causes
    mode = 3'd2; cyc(2);
    wdog = 1; cyc(1);
    check(rst_req == 1, "R11", rst_req, 1);
    cyc(1);
    check(rst_req == 0, "R11", rst_req, 0);
    wdog = 0; cyc(2);

    // random mix, compared every cycle with the model
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 199) == 0) mode = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 99) == 0) en = 9'($urandom);
      wdog = ($urandom_range(0, 29) == 0);
      spi  = ($urandom_range(0, 29) == 0);
      clr  = ($urandom_range(0, 9) == 0) ? 9'($urandom) : '0;
      if ($urandom_range(0, 11) == 0) temp  = ~temp;
      if ($urandom_range(0, 11) == 0) gnd   = ~gnd;
      if ($urandom_range(0, 11) == 0) sense = ~sense;
      if ($urandom_range(0, 15) == 0) v2    = ~v2;
      if ($urandom_range(0, 15) == 0) v3    = ~v3;
      if ($urandom_range(0, 11) == 0) can   = ~can;
      if ($urandom_range(0, 11) == 0) lin   = ~lin;
      if ($urandom_range(0, 11) == 0) wake  = ~wake;
      cyc(1);
    end
    wdog = 0; spi = 0; clr = '0;
    cyc(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule